// File: doc/BRIEF.md
# Background Configuration CRC Monitor

The block sweeps a configuration memory over and over while the rest of the chip runs. It reads one 32-bit word per clock through a synchronous read port, which returns data one cycle after the address. It folds each word into a CRC, and at the end of every sweep it compares the result with a reference CRC. Only the first sweep after each release has no check to make. That sweep builds the reference, and every sweep after it is checked against that reference. A mismatch raises a sticky internal error flag. The same mismatch pulls an active-low, open-drain style error pin low, and a parameter can disable that pin.

Sweeping may start only once the device reports that start-up is complete (`done_i`). It must also have seen a desync command since reset or since the last sync. Seven inputs each freeze the sweep and clear the flag:

- sync
- desync
- test-port reset
- abort
- internal reprogram
- suspend
- shutdown

When all of them drop, the block rebuilds the reference from a fresh sweep and resumes checking without outside help, provided that automatic checking is enabled.

Top module: `crc_scrub_mon`

## Requirements
- R1: `crc_o` holds the CRC of the last finished sweep, and `scan_done_o` pulses high for one cycle in the cycle `crc_o` updates. The CRC is CRC-32 with polynomial 0x04C11DB7 and starts at 0xFFFFFFFF. Words are fed from address 0 up to WORDS-1, bit 31 first, with no reflection and no final inversion.
- R2: `mem_rd_o` is high only while `en_i` is high. A low `en_i` pauses the sweep without changing its CRC.
- R3: The first sweep after a release never raises an error, and its CRC becomes the reference.
- R4: When a checking sweep ends with a CRC that differs from the reference, `err_o` rises in the same cycle as `scan_done_o`, and `err_pin_no` goes low. `done_o` keeps following `done_i`. After reset, `err_o` is 0, `err_pin_no` is 1 and no read is issued.
- R5: `err_o` stays high through later matching sweeps until `clr_i` or a halt input clears it. It is low from the edge that samples `clr_i` high.
- R6: While any halt input is high, `mem_rd_o` is low. The edge that samples a halt input clears `err_o`.
- R7: Once no halt input is active, the next sweep rebuilds the reference from current memory contents, and checking against it resumes.
- R8: After reset or a `sync_i`, no read is issued until `desync_i` has been seen.
- R9: While `done_i` is low, no read is issued.
- R10: With PIN_EN=0, `err_pin_no` stays high while `err_o` still reports mismatches.
- R11: With AUTO_EN=0, the block never reads memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| en_i | input | 1 | sweep advance enable |
| done_i | input | 1 | start-up complete |
| sync_i | input | 1 | sync command seen (halt, locks out) |
| desync_i | input | 1 | desync command seen (halt, releases lockout) |
| tap_rst_i | input | 1 | test-access-port reset (halt) |
| abort_i | input | 1 | abort request (halt) |
| reprog_i | input | 1 | internal reprogram command (halt) |
| suspend_i | input | 1 | suspend mode (halt) |
| shutdown_i | input | 1 | shutdown state (halt) |
| clr_i | input | 1 | clear error flag |
| mem_rd_o | output | 1 | memory read strobe |
| mem_addr_o | output | AW | memory word address |
| mem_data_i | input | 32 | read data, one cycle after the strobe |
| crc_o | output | 32 | CRC of the last finished sweep |
| scan_done_o | output | 1 | one-cycle pulse at the end of each sweep |
| err_o | output | 1 | sticky CRC error flag |
| err_pin_no | output | 1 | active-low error pin, released (1) when idle or disabled |
| done_o | output | 1 | copy of done_i, unaffected by errors |

## Verification
The bench flips a word in the middle of a sweep and expects exactly that sweep to fail. It then restores the word and expects the flag to hold until it is cleared. A design that compared against the wrong reference would fail here, and so would one that cleared the flag itself after a good sweep.

The bench walks each halt input with the memory left altered. It expects the flag to clear on that edge. It then expects the following sweep to pass silently, because the reference is rebuilt, and the sweep after it to pass as a check. A design that kept the old reference would report a false error.

The bench withholds desync and drops `done_i`, and expects no read at all. It also stalls `en_i` in the middle of a sweep, which catches a design that folds stale read data into the CRC.

// File: rtl/crc_mon_pkg.sv
package crc_mon_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCKED,
    ST_GOLDEN,
    ST_CHECK,
    ST_HALTED
  } mon_state_e;

  // MSB-first word update, no reflection
  function automatic logic [WORD_W-1:0] crc32_word(input logic [WORD_W-1:0] c,
                                                   input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (r[WORD_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else                    r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_mon_addr_gen.sv
module crc_mon_addr_gen #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          en_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          vld_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);

  logic [AW-1:0] addr_q;
  logic          vld_q;
  logic          last_q;

  assign rd_o   = run_i & en_i;
  assign addr_o = addr_q;
  assign vld_o  = vld_q;
  assign last_o = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (!run_i) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= en_i;
      last_q <= en_i && (addr_q == LAST_A);
      if (en_i) addr_q <= (addr_q == LAST_A) ? '0 : addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/crc_mon_crc32.sv
module crc_mon_crc32 import crc_mon_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              vld_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              fin_o,
  output logic [WORD_W-1:0] fin_crc_o,
  output logic [WORD_W-1:0] crc_o,
  output logic              scan_done_o
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] crc_q;
  logic [WORD_W-1:0] nxt;
  logic              done_q;

  assign nxt         = crc32_word(acc_q, data_i);
  assign fin_o       = run_i & vld_i & last_i;
  assign fin_crc_o   = nxt;
  assign crc_o       = crc_q;
  assign scan_done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= CRC_SEED;
      crc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (fin_o) crc_q <= nxt;
      if (!run_i)     acc_q <= CRC_SEED;
      else if (vld_i) acc_q <= last_i ? CRC_SEED : nxt;
    end
  end
endmodule

// File: rtl/crc_mon_err_flag.sv
module crc_mon_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;
  assign err_o = err_q;

  // clear wins over a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (clr_i) err_q <= 1'b0;
    else if (set_i) err_q <= 1'b1;
  end
endmodule

// File: rtl/crc_scrub_mon.sv
module crc_scrub_mon import crc_mon_pkg::*; #(
  parameter int unsigned WORDS   = 16,
  parameter bit          PIN_EN  = 1'b1,
  parameter bit          AUTO_EN = 1'b1,
  localparam int unsigned AW     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              done_i,
  input  logic              sync_i,
  input  logic              desync_i,
  input  logic              tap_rst_i,
  input  logic              abort_i,
  input  logic              reprog_i,
  input  logic              suspend_i,
  input  logic              shutdown_i,
  input  logic              clr_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [WORD_W-1:0] crc_o,
  output logic              scan_done_o,
  output logic              err_o,
  output logic              err_pin_no,
  output logic              done_o
);
  mon_state_e        state_q, state_d;
  logic              lock_q;
  logic [WORD_W-1:0] golden_q;
  logic              halt_any;
  logic              scan_go;
  logic              vld, last, fin;
  logic [WORD_W-1:0] fin_crc;
  logic              mis_set;

  assign halt_any = sync_i | desync_i | tap_rst_i | abort_i |
                    reprog_i | suspend_i | shutdown_i;
  assign scan_go  = done_i & ~halt_any &
                    ((state_q == ST_GOLDEN) | (state_q == ST_CHECK));
  assign done_o   = done_i;

  always_comb begin
    state_d = state_q;
    if (!done_i)       state_d = ST_IDLE;
    else if (halt_any) state_d = ST_HALTED;
    else if (lock_q)   state_d = ST_LOCKED;
    else begin
      unique case (state_q)
        ST_GOLDEN: if (fin) state_d = ST_CHECK;
        ST_CHECK:  state_d = ST_CHECK;
        default:   state_d = AUTO_EN ? ST_GOLDEN : state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      lock_q   <= 1'b1;
      golden_q <= '0;
    end else begin
      state_q <= state_d;
      if (sync_i)        lock_q <= 1'b1;
      else if (desync_i) lock_q <= 1'b0;
      if (state_q == ST_GOLDEN && fin) golden_q <= fin_crc;
    end
  end

  assign mis_set = (state_q == ST_CHECK) & fin & (fin_crc != golden_q);

  crc_mon_addr_gen #(.WORDS(WORDS), .AW(AW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (scan_go),
    .en_i   (en_i),
    .addr_o (mem_addr_o),
    .rd_o   (mem_rd_o),
    .vld_o  (vld),
    .last_o (last)
  );

  crc_mon_crc32 u_crc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (scan_go),
    .vld_i       (vld),
    .last_i      (last),
    .data_i      (mem_data_i),
    .fin_o       (fin),
    .fin_crc_o   (fin_crc),
    .crc_o       (crc_o),
    .scan_done_o (scan_done_o)
  );

  crc_mon_err_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mis_set),
    .clr_i  (clr_i | halt_any),
    .err_o  (err_o)
  );

  generate
    if (PIN_EN) begin : g_pin
      assign err_pin_no = ~err_o;
    end else begin : g_nopin
      assign err_pin_no = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/crc_scrub_mon_chk.sv
module crc_scrub_mon_chk #(
  parameter bit PIN_EN = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic done_i,
  input logic sync_i,
  input logic desync_i,
  input logic tap_rst_i,
  input logic abort_i,
  input logic reprog_i,
  input logic suspend_i,
  input logic shutdown_i,
  input logic clr_i,
  input logic mem_rd_o,
  input logic scan_done_o,
  input logic err_o,
  input logic err_pin_no
);
  logic halt;
  assign halt = sync_i | desync_i | tap_rst_i | abort_i | reprog_i | suspend_i | shutdown_i;

  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o);
  a_r2_rd_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> en_i);
  a_r4_err_rises_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> scan_done_o);
  a_r4_pin_needs_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_pin_no |-> err_o);
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i && !halt) |=> err_o);
  a_r5_clr_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_o);
  a_r6_halt_no_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |-> !mem_rd_o);
  a_r6_halt_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !err_o);
  a_r8_sync_stops_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !mem_rd_o);
  a_r9_rd_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> !mem_rd_o);

  generate
    if (!PIN_EN) begin : g_nopin
      a_r10_pin_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pin_no);
    end
  endgenerate
endmodule

bind crc_scrub_mon crc_scrub_mon_chk #(.PIN_EN(PIN_EN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .done_i      (done_i),
  .sync_i      (sync_i),
  .desync_i    (desync_i),
  .tap_rst_i   (tap_rst_i),
  .abort_i     (abort_i),
  .reprog_i    (reprog_i),
  .suspend_i   (suspend_i),
  .shutdown_i  (shutdown_i),
  .clr_i       (clr_i),
  .mem_rd_o    (mem_rd_o),
  .scan_done_o (scan_done_o),
  .err_o       (err_o),
  .err_pin_no  (err_pin_no)
);

// File: tb/sim_crc_scrub_mon.sv
module sim_crc_scrub_mon;
  localparam int unsigned WORDS = 16;
  localparam int unsigned AW    = $clog2(WORDS);
  localparam int NH = 7;
  // halt input index: 0 sync 1 desync 2 tap 3 abort 4 reprog 5 suspend 6 shutdown
  localparam int HSEL [NH] = '{3, 0, 4, 1, 6, 2, 5};
  localparam int FLIPA[NH] = '{5, 7, 9, 11, 13, 15, 6};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1, done_i = 1'b0, clr_i = 1'b0;
  logic sync_i = 1'b0, desync_i = 1'b0, tap_rst_i = 1'b0, abort_i = 1'b0;
  logic reprog_i = 1'b0, suspend_i = 1'b0, shutdown_i = 1'b0;

  logic [31:0] mem [WORDS];
  logic          rd0, rd1, rd2;
  logic [AW-1:0] a0, a1, a2;
  logic [31:0]   q0, q1, q2, crc0, crc1, crc2;
  logic sd0, sd1, sd2, err0, err1, err2, pin0, pin1, pin2, dn0, dn1, dn2;

  int total = 0, bad = 0, cyc = 0, u2_rd = 0, gap_viol = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  crc_scrub_mon #(.WORDS(WORDS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .done_i(done_i), .sync_i(sync_i),
    .desync_i(desync_i), .tap_rst_i(tap_rst_i), .abort_i(abort_i), .reprog_i(reprog_i),
    .suspend_i(suspend_i), .shutdown_i(shutdown_i), .clr_i(clr_i), .mem_rd_o(rd0),
    .mem_addr_o(a0), .mem_data_i(q0), .crc_o(crc0), .scan_done_o(sd0), .err_o(err0),
    .err_pin_no(pin0), .done_o(dn0));

  crc_scrub_mon #(.WORDS(WORDS), .PIN_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .done_i(done_i), .sync_i(sync_i),
    .desync_i(desync_i), .tap_rst_i(tap_rst_i), .abort_i(abort_i), .reprog_i(reprog_i),
    .suspend_i(suspend_i), .shutdown_i(shutdown_i), .clr_i(clr_i), .mem_rd_o(rd1),
    .mem_addr_o(a1), .mem_data_i(q1), .crc_o(crc1), .scan_done_o(sd1), .err_o(err1),
    .err_pin_no(pin1), .done_o(dn1));

  crc_scrub_mon #(.WORDS(WORDS), .AUTO_EN(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .done_i(done_i), .sync_i(sync_i),
    .desync_i(desync_i), .tap_rst_i(tap_rst_i), .abort_i(abort_i), .reprog_i(reprog_i),
    .suspend_i(suspend_i), .shutdown_i(shutdown_i), .clr_i(clr_i), .mem_rd_o(rd2),
    .mem_addr_o(a2), .mem_data_i(q2), .crc_o(crc2), .scan_done_o(sd2), .err_o(err2),
    .err_pin_no(pin2), .done_o(dn2));

  always @(posedge clk) begin
    if (rd0) q0 <= mem[a0];
    if (rd1) q1 <= mem[a1];
    if (rd2) q2 <= mem[a2];
  end

  always @(negedge clk) if (rd2) u2_rd++;

  function automatic logic [31:0] ref_crc();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < WORDS; w++)
      for (int b = 31; b >= 0; b--) begin
        logic fb = c[31] ^ mem[w][b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_halt(input int k, input logic v);
    case (k)
      0: sync_i = v;
      1: desync_i = v;
      2: tap_rst_i = v;
      3: abort_i = v;
      4: reprog_i = v;
      5: suspend_i = v;
      default: shutdown_i = v;
    endcase
  endtask

  task automatic wait_scan(input string req, input bit gappy);
    int k = 0;
    en_i = 1'b1;
    do begin
      @(negedge clk);
      if (!en_i && rd0) gap_viol++;
      k++;
      if (gappy) en_i = (k % 3) != 0;
    end while (!sd0 && k < 400);
    en_i = 1'b1;
    if (!sd0) chk({req, " scan_done timeout"}, 32'd0, 32'd1);
  endtask

  task automatic count_rd(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rd0) c++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c;
    for (int i = 0; i < WORDS; i++) mem[i] = (32'h9E37_79B9 * (i + 1)) ^ {16'(i), 16'hA5C3};

    // reset state (R4)
    repeat (3) @(negedge clk);
    chk("R4 reset err", {31'd0, err0}, 32'd0);
    chk("R4 reset pin", {31'd0, pin0}, 32'd1);
    chk("R4 reset rd", {31'd0, rd0}, 32'd0);
    rst_ni = 1'b1;

    // done high, no desync: locked (R8)
    done_i = 1'b1;
    count_rd(40, c);
    chk("R8 no read before desync", c, 0);

    // desync with done low, then done low window (R9)
    done_i = 1'b0;
    @(negedge clk); desync_i = 1'b1;
    @(negedge clk); desync_i = 1'b0;
    count_rd(40, c);
    chk("R9 no read while done low", c, 0);
    chk("R9 done_o follows", {31'd0, dn0}, 32'd0);
    done_i = 1'b1;

    // golden then check (R1, R3)
    wait_scan("R3 golden", 1'b0);
    chk("R1 golden crc", crc0, ref_crc());
    chk("R3 golden no err", {31'd0, err0}, 32'd0);
    wait_scan("R3 check", 1'b0);
    chk("R3 check matches", {31'd0, err0}, 32'd0);
    chk("R1 check crc", crc0, ref_crc());

    // stalled sweep (R2)
    wait_scan("R2 gappy", 1'b1);
    chk("R2 gappy crc", crc0, ref_crc());
    chk("R2 gappy no err", {31'd0, err0}, 32'd0);
    chk("R2 no read with en low", gap_viol, 0);

    // mismatch and sticky (R4, R5, R10)
    mem[4] = mem[4] ^ 32'h0000_0100;
    wait_scan("R4 flip", 1'b0);
    chk("R4 err set", {31'd0, err0}, 32'd1);
    chk("R4 pin low", {31'd0, pin0}, 32'd0);
    chk("R4 done_o high", {31'd0, dn0}, 32'd1);
    chk("R1 flipped crc", crc0, ref_crc());
    chk("R10 err works w/o pin", {31'd0, err1}, 32'd1);
    chk("R10 pin released", {31'd0, pin1}, 32'd1);
    mem[4] = mem[4] ^ 32'h0000_0100;
    wait_scan("R5 restored", 1'b0);
    chk("R5 err sticky", {31'd0, err0}, 32'd1);
    wait_scan("R5 restored2", 1'b0);
    chk("R5 err sticky 2", {31'd0, err0}, 32'd1);
    clr_i = 1'b1;
    @(negedge clk);
    chk("R5 clear", {31'd0, err0}, 32'd0);
    clr_i = 1'b0;
    wait_scan("R5 after clear", 1'b0);
    chk("R5 stays clear on match", {31'd0, err0}, 32'd0);

    // halt table (R6, R7, R8)
    for (int e = 0; e < NH; e++) begin
      wait_scan("R6 pre", 1'b0);
      mem[FLIPA[e]] = mem[FLIPA[e]] ^ (32'd1 << e);
      wait_scan("R6 mismatch", 1'b0);
      chk("R6 err before halt", {31'd0, err0}, 32'd1);
      drive_halt(HSEL[e], 1'b1);
      @(negedge clk);
      chk("R6 halt clears err", {31'd0, err0}, 32'd0);
      chk("R6 halt blocks read", {31'd0, rd0}, 32'd0);
      drive_halt(HSEL[e], 1'b0);
      if (HSEL[e] == 0) begin
        count_rd(40, c);
        chk("R8 sync locks out", c, 0);
        desync_i = 1'b1;
        @(negedge clk);
        desync_i = 1'b0;
      end
      wait_scan("R7 regolden", 1'b0);
      chk("R7 regolden no err", {31'd0, err0}, 32'd0);
      chk("R7 regolden crc", crc0, ref_crc());
      wait_scan("R7 recheck", 1'b0);
      chk("R7 recheck no err", {31'd0, err0}, 32'd0);
    end

    // done drops while checking (R9)
    done_i = 1'b0;
    @(negedge clk);
    chk("R9 read stops", {31'd0, rd0}, 32'd0);
    chk("R9 done_o low", {31'd0, dn0}, 32'd0);
    count_rd(30, c);
    chk("R9 no read window", c, 0);

    chk("R11 no auto sweep", u2_rd, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule